// File: doc/BRIEF.md
# Shared Memory Window Packet Bridge

This block sits on a local processor's memory bus and claims one fixed physical address window that maps onto memory owned by a remote processor. Each local read or write that falls inside the window becomes a short byte-serial request packet on an outbound stream. The block then parses the reply packet from an inbound stream and completes the local cycle with the returned word or with an error indication. Addresses outside the window are left alone, and the `hit` output lets the surrounding fabric route them elsewhere.

The local side follows a hold-until-acknowledge rule. The processor raises `req` with the address, direction and write data, and keeps them steady until `ack` pulses for one cycle. Only one transaction is in flight at a time. The local port stays stalled from the first request byte until the reply has been fully taken in, until the reply is judged malformed, or until the programmable reply timer runs out. When `en` is low, the remote side is treated as absent. In-window cycles then complete at once with zero data, and no packet is sent.

Top module: `rmw_bridge`

## Requirements
- R1: `hit` is high exactly when `addr` lies in [octal 3000000, octal 3040000). That range is 16384 words starting at block 48 of 16384-word blocks.
- R2: A request with `hit` low is never acknowledged and produces no outbound byte.
- R3: A read request is sent as the bytes 4, 2, A[7:0], {2'b0, A[13:8]}, 0. Only the low 14 address bits are carried.
- R4: A write request is sent as the bytes 9, 1, the three address bytes of R3, then the five bytes of the 36-bit write word zero-extended to 40 bits, least significant byte first.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` does not change.
- R6: A reply is a length byte L (1 to 7) followed by L bytes, and the first of those bytes is the reply code. For a read, a code of 3 (acknowledge) returns bytes 2 to 6 of the body assembled least significant first and truncated to 36 bits. Missing bytes read as zero. `nxm` stays low.
- R7: Reply code 4 (error) or 5 (remote timeout) completes the cycle with `rdata` zero and `nxm` low.
- R8: Any other reply code, including the reserved interrupt code 6, completes the cycle with `nxm` high and `rdata` zero.
- R9: A reply length byte of 0 or more than 7 completes the cycle right away with `nxm` high, without waiting for further bytes.
- R10: If no complete reply arrives, `ack` rises exactly `tmo_limit`+1 cycles after the clock edge that takes the last request byte, with `rdata` zero and `nxm` low.
- R11: With `en` low, an in-window request is acknowledged on the next cycle with zero data and `nxm` low, and no byte is sent.
- R12: `ack` is a one-cycle pulse. `rx_ready` is high only while a reply is awaited.
- R13: During and just after reset, `ack`, `tx_valid` and `rx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Remote side present; when low, window cycles complete locally |
| tmo_limit | input | TMO_W | Reply wait limit in cycles |
| req | input | 1 | Local cycle request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Physical word address |
| wdata | input | WORD_W | Write word |
| hit | output | 1 | Address lies in the bridge window |
| ack | output | 1 | One-cycle cycle-complete pulse |
| rdata | output | WORD_W | Read word, valid with ack |
| nxm | output | 1 | Nonexistent-memory error, valid with ack |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Outbound byte taken |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Inbound byte accepted |
| rx_data | input | 8 | Inbound byte |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a 36-bit word, the window at octal 3000000 with 14 offset bits, and an 8-bit timer limit. A 20-bit address splits into only 64 window-sized blocks, so the decoder is swept over every block and over both edges of the window. With the 14 offset bits, a walking one can cross each address byte boundary. The small timer width lets several limits be checked cycle-exactly. Every reply code of interest and every out-of-range length is played back against both reads and writes.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam logic [7:0] OP_WRITE = 8'd1;
    localparam logic [7:0] OP_READ  = 8'd2;
    localparam logic [7:0] RC_ACK   = 8'd3;
    localparam logic [7:0] RC_ERR   = 8'd4;
    localparam logic [7:0] RC_TMO   = 8'd5;

    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = 5;
    localparam int MAX_REPLY  = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_ACK
    } rmw_state_e;

    typedef struct packed {
        logic                      wr;
        logic [8*ADDR_BYTES-1:0]   addr;
        logic [8*DATA_BYTES-1:0]   data;
    } rmw_req_t;

    function automatic logic [3:0] req_last(input logic wr);
        return wr ? 4'(1 + ADDR_BYTES + DATA_BYTES) : 4'(1 + ADDR_BYTES);
    endfunction

    function automatic logic [7:0] req_byte(input rmw_req_t r, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'(req_last(r.wr));
            4'd1:    b = r.wr ? OP_WRITE : OP_READ;
            4'd2:    b = r.addr[7:0];
            4'd3:    b = r.addr[15:8];
            4'd4:    b = r.addr[23:16];
            4'd5:    b = r.data[7:0];
            4'd6:    b = r.data[15:8];
            4'd7:    b = r.data[23:16];
            4'd8:    b = r.data[31:24];
            4'd9:    b = r.data[39:32];
            default: b = 8'd0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rmw_window.sv
module rmw_window #(
    parameter int          ADDR_W   = 20,
    parameter int unsigned WIN_BASE = 'o3000000,
    parameter int          WIN_BITS = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);

    assign hit = (addr[ADDR_W-1:WIN_BITS] == BASE_V[ADDR_W-1:WIN_BITS]);

    always_comb begin
        a_r1_base_aligned: assert (BASE_V[WIN_BITS-1:0] == '0);
    end
endmodule

// File: rtl/rmw_req_tx.sv
module rmw_req_tx
    import rmw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     active,
    input  rmw_req_t req,
    input  logic     tx_ready,
    output logic     tx_valid,
    output logic [7:0] tx_data,
    output logic     done
);
    logic [3:0] idx;

    assign tx_valid = active;
    assign tx_data  = req_byte(req, idx);
    assign done     = active && tx_ready && (idx == req_last(req.wr));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (start) begin
            idx <= '0;
        end else if (active && tx_ready) begin
            idx <= idx + 4'd1;
        end
    end

    a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: rtl/rmw_reply_rx.sv
module rmw_reply_rx
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       active,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    output logic       done,
    output logic       bad,
    output logic [7:0] code,
    output logic [8*DATA_BYTES-1:0] word
);
    logic       have_len;
    logic       fin;
    logic [3:0] len;
    logic [3:0] pos;
    logic       take;

    assign rx_ready = active && !fin;
    assign take     = rx_ready && rx_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_len <= 1'b0;
            fin      <= 1'b0;
            len      <= '0;
            pos      <= '0;
            done     <= 1'b0;
            bad      <= 1'b0;
            code     <= '0;
            word     <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                have_len <= 1'b0;
                fin      <= 1'b0;
                len      <= '0;
                pos      <= '0;
                bad      <= 1'b0;
                code     <= '0;
                word     <= '0;
            end else if (take) begin
                if (!have_len) begin
                    if (rx_data == 8'd0 || rx_data > 8'(MAX_REPLY)) begin
                        fin  <= 1'b1;
                        done <= 1'b1;
                        bad  <= 1'b1;
                    end else begin
                        len      <= rx_data[3:0];
                        have_len <= 1'b1;
                    end
                end else begin
                    if (pos == 4'd0) begin
                        code <= rx_data;
                    end
                    for (int k = 0; k < DATA_BYTES; k++) begin
                        if (pos == 4'(k + 1)) begin
                            word[8*k +: 8] <= rx_data;
                        end
                    end
                    pos <= pos + 4'd1;
                    if (pos + 4'd1 == len) begin
                        fin  <= 1'b1;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    a_r9_bad_length_ends: assert property (@(posedge clk) disable iff (rst)
        (take && !have_len && !start && (rx_data == 8'd0 || rx_data > 8'(MAX_REPLY)))
        |=> (done && bad));

    a_r12_stop_after_done: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |-> !rx_ready);
endmodule

// File: rtl/rmw_bridge.sv
module rmw_bridge
    import rmw_pkg::*;
#(
    parameter int          ADDR_W   = 20,
    parameter int          WORD_W   = 36,
    parameter int unsigned WIN_BASE = 'o3000000,
    parameter int          WIN_BITS = 14,
    parameter int          TMO_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic              hit,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic              nxm,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data
);
    localparam int AW_PKT = 8 * ADDR_BYTES;
    localparam int DW_PKT = 8 * DATA_BYTES;

    rmw_state_e          state;
    rmw_req_t            req_q;
    logic [TMO_W-1:0]    tmo_cnt;
    logic [WORD_W-1:0]   rdata_q;
    logic                nxm_q;
    logic                start;
    logic                tx_done;
    logic                rx_done;
    logic                rx_bad;
    logic [7:0]          rx_code;
    logic [DW_PKT-1:0]   rx_word;

    rmw_window #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .WIN_BITS(WIN_BITS)
    ) i_window (
        .addr(addr),
        .hit (hit)
    );

    assign start = (state == ST_IDLE) && req && hit && en;

    rmw_req_tx i_tx (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .active  (state == ST_SEND),
        .req     (req_q),
        .tx_ready(tx_ready),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .done    (tx_done)
    );

    rmw_reply_rx i_rx (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .active  (state == ST_WAIT),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_ready(rx_ready),
        .done    (rx_done),
        .bad     (rx_bad),
        .code    (rx_code),
        .word    (rx_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            req_q   <= '0;
            tmo_cnt <= '0;
            rdata_q <= '0;
            nxm_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req && hit) begin
                        rdata_q <= '0;
                        nxm_q   <= 1'b0;
                        if (en) begin
                            req_q.wr   <= we;
                            req_q.addr <= {{(AW_PKT-WIN_BITS){1'b0}}, addr[WIN_BITS-1:0]};
                            req_q.data <= {{(DW_PKT-WORD_W){1'b0}}, wdata};
                            state      <= ST_SEND;
                        end else begin
                            state <= ST_ACK;
                        end
                    end
                end
                ST_SEND: begin
                    if (tx_done) begin
                        tmo_cnt <= '0;
                        state   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rx_done) begin
                        state <= ST_ACK;
                        if (rx_bad) begin
                            nxm_q <= 1'b1;
                        end else begin
                            case (rx_code)
                                RC_ACK: begin
                                    if (!req_q.wr) begin
                                        rdata_q <= rx_word[WORD_W-1:0];
                                    end
                                end
                                RC_ERR, RC_TMO: nxm_q <= 1'b0;
                                default:        nxm_q <= 1'b1;
                            endcase
                        end
                    end else if (tmo_cnt == tmo_limit) begin
                        state <= ST_ACK;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign ack   = (state == ST_ACK);
    assign rdata = rdata_q;
    assign nxm   = nxm_q;

    a_r2_miss_ignored: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && req && !hit) |=> (!ack && !tx_valid));

    a_r11_local_complete: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && req && hit && !en) |=> (ack && !nxm && rdata == '0));

    a_r12_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    a_r12_one_direction: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && rx_ready));

    a_r8_error_zero_data: assert property (@(posedge clk) disable iff (rst)
        (ack && nxm) |-> (rdata == '0));
endmodule

// File: tb/test_rmw_bridge.sv
module test_rmw_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic [7:0]  tmo_limit = 8'd40;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [19:0] addr = '0;
    logic [35:0] wdata = '0;
    logic        hit, ack, nxm, tx_valid, rx_ready;
    logic [35:0] rdata;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    int tests = 0;
    int fails = 0;
    logic [7:0] rep [16];
    int rep_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rmw_bridge i_rmw_bridge (
        .clk(clk), .rst(rst), .en(en), .tmo_limit(tmo_limit),
        .req(req), .we(we), .addr(addr), .wdata(wdata),
        .hit(hit), .ack(ack), .rdata(rdata), .nxm(nxm),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
    );

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input bit wr, input logic [19:0] a, input logic [35:0] d, input int k);
        logic [39:0] dd;
        dd = {4'b0, d};
        case (k)
            0: return wr ? 8'd9 : 8'd4;
            1: return wr ? 8'd1 : 8'd2;
            2: return a[7:0];
            3: return {2'b0, a[13:8]};
            4: return 8'd0;
            default: return dd[8*(k-5) +: 8];
        endcase
    endfunction

    // Runs one window cycle: checks request bytes, plays rep[], waits for ack.
    task automatic txn(input bit wr, input logic [19:0] a, input logic [35:0] d,
                       input int stall_at, input string rq,
                       output logic [35:0] got_d, output logic got_nxm, output int waited);
        int nb;
        int g;
        logic [7:0] b;
        nb = wr ? 10 : 5;
        @(negedge clk);
        we = wr; addr = a; wdata = d; req = 1'b1;
        for (int k = 0; k < nb; k++) begin
            g = 0;
            @(negedge clk);
            while (!tx_valid && g < 50) begin @(negedge clk); g++; end
            b = tx_data;
            check(tx_valid && b == exp_byte(wr, a, d, k), rq, {56'd0, b}, {56'd0, exp_byte(wr, a, d, k)});
            if (k == stall_at) begin
                tx_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check(tx_valid && tx_data == b, "R5 stall hold", {56'd0, tx_data}, {56'd0, b});
                end
                tx_ready = 1'b1;
            end
        end
        for (int j = 0; j < rep_n; j++) begin
            g = 0;
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rep[j];
            while (!rx_ready && g < 50) begin @(negedge clk); g++; end
        end
        waited = 0;
        if (rep_n > 0) begin
            @(negedge clk);
            rx_valid = 1'b0;
        end
        while (!ack && waited < 1000) begin
            @(negedge clk);
            if (!ack) waited++;
        end
        check(ack, "R12 ack seen", {63'd0, ack}, 64'd1);
        got_d = rdata; got_nxm = nxm;
        req = 1'b0;
        @(negedge clk);
        check(!ack, "R12 ack one cycle", {63'd0, ack}, 64'd0);
    endtask

    task automatic set_rep_read_ack(input int len, input logic [39:0] v);
        rep[0] = 8'(len); rep[1] = 8'd3;
        for (int k = 0; k < 5; k++) rep[2+k] = v[8*k +: 8];
        rep_n = len + 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [35:0] gd;
        logic gn;
        int w;
        logic [39:0] v;
        logic [35:0] exp_d;

        repeat (3) @(negedge clk);
        check(!ack && !tx_valid && !rx_ready, "R13 in reset", {61'd0, ack, tx_valid, rx_ready}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!ack && !tx_valid && !rx_ready, "R13 after reset", {61'd0, ack, tx_valid, rx_ready}, 64'd0);

        // R1: every 16K block of the 20-bit space, plus window edges
        for (int k = 0; k < 64; k++) begin
            addr = 20'(k << 14);
            #1;
            check(hit == (k == 48), "R1 block sweep", {63'd0, hit}, {63'd0, 1'(k == 48)});
        end
        addr = 20'o2777777; #1; check(!hit, "R1 below base", {63'd0, hit}, 64'd0);
        addr = 20'o3000000; #1; check(hit,  "R1 base", {63'd0, hit}, 64'd1);
        addr = 20'o3037777; #1; check(hit,  "R1 top", {63'd0, hit}, 64'd1);
        addr = 20'o3040000; #1; check(!hit, "R1 past top", {63'd0, hit}, 64'd0);

        // R2: out-of-window request is ignored
        @(negedge clk);
        addr = 20'o3040000; req = 1'b1; we = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(!ack && !tx_valid, "R2 miss ignored", {62'd0, ack, tx_valid}, 64'd0);
        end
        req = 1'b0;
        @(negedge clk);
        check(!rx_ready, "R12 rx idle", {63'd0, rx_ready}, 64'd0);

        // R3 + R6: walking-one reads with acknowledge replies
        for (int i = 0; i < 14; i++) begin
            v = 40'hF0_1234_5678 ^ (40'h1 << (i * 2));
            set_rep_read_ack(6, v);
            txn(1'b0, 20'o3000000 | 20'(1 << i), '0, -1, "R3 read frame", gd, gn, w);
            check(gd == v[35:0] && !gn, "R6 read data", {27'd0, gn, gd}, {28'd0, v[35:0]});
        end

        // R6: short acknowledge, missing bytes read zero
        set_rep_read_ack(3, 40'hAB_CDEF_1122);
        txn(1'b0, 20'o3012345, '0, -1, "R3 read frame", gd, gn, w);
        exp_d = 36'h0000_1122;
        check(gd == exp_d && !gn, "R6 short reply", {27'd0, gn, gd}, {28'd0, exp_d});

        // R4 + R5: writes with several data patterns, one with a stall
        for (int i = 0; i < 4; i++) begin
            v = {4'd0, 36'h9_8765_4321} ^ (40'h0F_0F0F_0F0F << i);
            rep[0] = 8'd1; rep[1] = 8'd3; rep_n = 2;
            txn(1'b1, 20'o3020000 + 20'(i * 'o1111), v[35:0], (i == 1) ? 6 : -1, "R4 write frame", gd, gn, w);
            check(!gn, "R4 write ack", {63'd0, gn}, 64'd0);
        end

        // R7: error and remote-timeout codes
        for (int c = 4; c <= 5; c++) begin
            rep[0] = 8'd6; rep[1] = 8'(c);
            for (int k = 2; k < 7; k++) rep[k] = 8'hFF;
            rep_n = 7;
            txn(1'b0, 20'o3000777, '0, -1, "R3 read frame", gd, gn, w);
            check(gd == '0 && !gn, "R7 err/tmo code", {27'd0, gn, gd}, 64'd0);
            rep[0] = 8'd1; rep_n = 2;
            txn(1'b1, 20'o3000777, 36'hFFFF, -1, "R4 write frame", gd, gn, w);
            check(!gn, "R7 err/tmo write", {63'd0, gn}, 64'd0);
        end

        // R8: protocol errors
        foreach (rep[i]) rep[i] = 8'h55;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] cc;
            cc = (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : (i == 2) ? 8'd2 :
                 (i == 3) ? 8'd6 : (i == 4) ? 8'd7 : 8'hFF;
            rep[0] = 8'd6; rep[1] = cc; rep_n = 7;
            txn(1'b0, 20'o3000100, '0, -1, "R3 read frame", gd, gn, w);
            check(gn && gd == '0, "R8 bad code", {27'd0, gn, gd}, {27'd0, 1'b1, 36'd0});
        end

        // R9: malformed lengths
        for (int i = 0; i < 3; i++) begin
            rep[0] = (i == 0) ? 8'd0 : (i == 1) ? 8'd8 : 8'hFF;
            rep_n = 1;
            txn(i == 2, 20'o3000200, 36'h5, -1, (i == 2) ? "R4 write frame" : "R3 read frame", gd, gn, w);
            check(gn && gd == '0, "R9 malformed", {27'd0, gn, gd}, {27'd0, 1'b1, 36'd0});
        end

        // R10: timer limits, no reply
        for (int i = 0; i < 4; i++) begin
            logic [7:0] lim;
            lim = (i == 0) ? 8'd0 : (i == 1) ? 8'd1 : (i == 2) ? 8'd7 : 8'd25;
            tmo_limit = lim;
            rep_n = 0;
            txn(i[0], 20'o3033333, 36'h7, -1, i[0] ? "R4 write frame" : "R3 read frame", gd, gn, w);
            check(w == int'(lim) + 1, "R10 timeout cycles", 64'(w), 64'(int'(lim) + 1));
            check(gd == '0 && !gn, "R10 timeout result", {27'd0, gn, gd}, 64'd0);
        end
        tmo_limit = 8'd40;

        // R11: disabled remote
        en = 1'b0;
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 20'o3001234;
        @(negedge clk);
        check(ack && !tx_valid, "R11 local ack", {62'd0, ack, tx_valid}, 64'd2);
        check(rdata == '0 && !nxm, "R11 zero data", {27'd0, nxm, rdata}, 64'd0);
        we = 1'b1;
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        check(ack && !tx_valid && !nxm, "R11 write dropped", {61'd0, ack, tx_valid, nxm}, 64'd4);
        req = 1'b0;
        en = 1'b1;
        @(negedge clk);
        check(!ack && !tx_valid, "R11 no bytes after", {62'd0, ack, tx_valid}, 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule